// File: doc/BRIEF.md
# Dual compare-match 8-bit timer

This block is an 8-bit up-counter with two compare constants, an overflow flag and one waveform output. The counter advances by one on every cycle in which the count-enable input is high, and it wraps freely from all ones back to zero. When the counter steps onto the value held in a compare constant, the flag for that channel is set. The channel's 2-bit action code then decides what happens to the waveform output: it can leave the level alone, drive it low, drive it high or toggle it.

Software reaches the block through a small register bus with a 2-bit address, a read strobe, a write strobe and 8-bit data. Through it software can read and load the counter, both compare constants and one control/status byte. A status flag can only be cleared by software in two steps: a read that sees the flag as 1, then a write of 0. The two compare flags can also be cleared by a one-cycle acknowledge pulse from a transfer engine. The interrupt request outputs are the flag levels themselves.

Register map, by address: 0 is the counter, 1 is compare constant A, 2 is compare constant B, 3 is the control/status byte. Layout of the status byte: bit 7 is flag B, bit 6 is flag A, bit 5 is the overflow flag, bit 4 always reads 1, bits 3:2 hold the channel-B action code and bits 1:0 hold the channel-A action code.

Top module: `cm_timer8`

## Requirements
- R1: The counter increments by one on each clock with `cnt_en` high and wraps from 0xFF to 0x00. A bus write to address 0 loads the counter and takes priority over the increment.
- R2: Flag A (status bit 6) sets on the edge where the counter advances to the value of compare A. Flag B (status bit 7) sets in the same way for compare B.
- R3: The overflow flag (status bit 5) sets on the edge where the counter advances from 0xFF to 0x00.
- R4: A flag clears only when a write of 0 to its bit follows an earlier status read that returned 1 for that flag. A write of 0 with no such read leaves the flag at 1. Any status write consumes the armed read.
- R5: Writing 1 to a flag bit never sets the flag and never clears it.
- R6: A one-cycle pulse on `ack_a` or `ack_b` clears flag A or flag B. These pulses have no effect on the overflow flag.
- R7: When a flag's set condition and a clear fall in the same cycle, the flag stays set.
- R8: Status bit 4 always reads 1, and writes do not change it.
- R9: Action codes are 00 for no change, 01 to drive low, 10 to drive high and 11 to toggle. Bits 1:0 apply on a channel-A match and bits 3:2 apply on a channel-B match.
- R10: `wave_oe` is high exactly when any of the four action-code bits is 1. The output level is 0 after reset and changes only on a match.
- R11: When both channels match in the same cycle and channel B has a non-zero code, only the channel-B action is applied.
- R12: After reset the counter is 0x00, both compare constants are 0xFF, and all flags and action codes are 0, so the status byte reads 0x10.
- R13: A bus write to the counter causes no compare match and no overflow in that cycle, even when `cnt_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-enable pulse, one step per cycle high |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ack_a | input | 1 | Transfer-engine acknowledge for channel A |
| ack_b | input | 1 | Transfer-engine acknowledge for channel B |
| wave_out | output | 1 | Waveform output level |
| wave_oe | output | 1 | Waveform output enable |
| irq_a | output | 1 | Flag A level |
| irq_b | output | 1 | Flag B level |
| irq_ovf | output | 1 | Overflow flag level |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a channel-A match and a channel-B match against the same counter value. Vectors give both compare constants the same value with different action codes, and the output level is then judged against the channel-B action alone. The second pair is a flag being set and being cleared by software: a flag is armed by a read, and then a status write of 0 is issued in the very cycle the counter steps onto its compare value. The flag must still read as set afterwards.

// File: rtl/cm_timer8_pkg.sv
package cm_timer8_pkg;
   localparam int DATA_W = 8;

   localparam logic [1:0] ADR_COUNT = 2'd0;
   localparam logic [1:0] ADR_CMPA  = 2'd1;
   localparam logic [1:0] ADR_CMPB  = 2'd2;
   localparam logic [1:0] ADR_CTRL  = 2'd3;

   localparam int BIT_FB   = 7;
   localparam int BIT_FA   = 6;
   localparam int BIT_FOVF = 5;
   localparam int BIT_RSV  = 4;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } act_e;

   function automatic logic act_apply(input logic [1:0] code, input logic lvl);
      case (act_e'(code))
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         ACT_TOGGLE: return ~lvl;
         default:    return lvl;
      endcase
   endfunction
endpackage

// File: rtl/cm_timer8_count.sv
module cm_timer8_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             ld_cnt_i,
   input  logic             ld_a_i,
   input  logic             ld_b_i,
   input  logic [CNT_W-1:0] wval_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cmp_a_o,
   output logic [CNT_W-1:0] cmp_b_o,
   output logic             evt_a_o,
   output logic             evt_b_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] CMP_INIT = '1;

   logic [CNT_W-1:0] cnt_q, cmp_a_q, cmp_b_q, cnt_inc;
   logic             adv;

   assign adv     = en_i & ~ld_cnt_i;
   assign cnt_inc = cnt_q + CNT_W'(1);
   assign evt_a_o = adv & (cnt_inc == cmp_a_q);
   assign evt_b_o = adv & (cnt_inc == cmp_b_q);
   assign ovf_o   = adv & (&cnt_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         cmp_a_q <= CMP_INIT;
         cmp_b_q <= CMP_INIT;
      end else begin
         if (ld_cnt_i)  cnt_q <= wval_i;
         else if (en_i) cnt_q <= cnt_inc;
         if (ld_a_i)    cmp_a_q <= wval_i;
         if (ld_b_i)    cmp_b_q <= wval_i;
      end
   end

   assign cnt_o   = cnt_q;
   assign cmp_a_o = cmp_a_q;
   assign cmp_b_o = cmp_b_q;

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !ld_cnt_i) |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
   a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> cnt_q == '0);
   a_r13_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cnt_i |=> cnt_q == $past(wval_i));
endmodule

// File: rtl/cm_timer8_flag.sv
module cm_timer8_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic flag_q, armed_q, sw_clr;

   assign sw_clr = wr_i & ~wbit_i & armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (set_i)                 flag_q <= 1'b1;
         else if (ack_i || sw_clr)  flag_q <= 1'b0;
         if (rd_i && flag_q)        armed_q <= 1'b1;
         else if (wr_i || !flag_q)  armed_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   a_r5_set_by_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(set_i));
   a_r4_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(ack_i || (wr_i && !wbit_i && armed_q)));
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
endmodule

// File: rtl/cm_timer8_wave.sv
module cm_timer8_wave
   import cm_timer8_pkg::*;
#(
   parameter bit B_WINS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt_a_i,
   input  logic       evt_b_i,
   input  logic [1:0] code_a_i,
   input  logic [1:0] code_b_i,
   output logic       level_o
);
   logic level_q, level_d;

   generate
      if (B_WINS) begin : g_b_first
         always_comb begin
            if (evt_b_i && code_b_i != ACT_KEEP) level_d = act_apply(code_b_i, level_q);
            else if (evt_a_i)                    level_d = act_apply(code_a_i, level_q);
            else                                 level_d = level_q;
         end
      end else begin : g_a_first
         always_comb begin
            if (evt_a_i && code_a_i != ACT_KEEP) level_d = act_apply(code_a_i, level_q);
            else if (evt_b_i)                    level_d = act_apply(code_b_i, level_q);
            else                                 level_d = level_q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_d;
   end

   assign level_o = level_q;

   a_r10_hold_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_a_i || evt_b_i) |=> $stable(level_q));
   a_r9_keep_code: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_a_i && !evt_b_i && code_a_i == ACT_KEEP) |=> $stable(level_q));
endmodule

// File: rtl/cm_timer8.sv
module cm_timer8
   import cm_timer8_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter bit B_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic [1:0]        bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ack_a,
   input  logic              ack_b,
   output logic              wave_out,
   output logic              wave_oe,
   output logic              irq_a,
   output logic              irq_b,
   output logic              irq_ovf
);
   localparam int NFLAG = 3;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
         $error("cm_timer8: CNT_W must lie between 2 and DATA_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, cmp_a, cmp_b;
   logic             evt_a, evt_b, evt_ovf;
   logic             rd_ctrl, wr_ctrl;
   logic [3:0]       sel_q;
   logic [NFLAG-1:0] f_set, f_ack, f_wbit, f_val;

   assign rd_ctrl = bus_rd & (bus_addr == ADR_CTRL);
   assign wr_ctrl = bus_wr & (bus_addr == ADR_CTRL);

   cm_timer8_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (cnt_en),
      .ld_cnt_i (bus_wr & (bus_addr == ADR_COUNT)),
      .ld_a_i   (bus_wr & (bus_addr == ADR_CMPA)),
      .ld_b_i   (bus_wr & (bus_addr == ADR_CMPB)),
      .wval_i   (bus_wdata[CNT_W-1:0]),
      .cnt_o    (cnt),
      .cmp_a_o  (cmp_a),
      .cmp_b_o  (cmp_b),
      .evt_a_o  (evt_a),
      .evt_b_o  (evt_b),
      .ovf_o    (evt_ovf)
   );

   // flag index 0: A, 1: B, 2: overflow
   assign f_set  = {evt_ovf, evt_b, evt_a};
   assign f_ack  = {1'b0, ack_b, ack_a};
   assign f_wbit = {bus_wdata[BIT_FOVF], bus_wdata[BIT_FB], bus_wdata[BIT_FA]};

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         cm_timer8_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (f_set[i]),
            .ack_i  (f_ack[i]),
            .rd_i   (rd_ctrl),
            .wr_i   (wr_ctrl),
            .wbit_i (f_wbit[i]),
            .flag_o (f_val[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       sel_q <= '0;
      else if (wr_ctrl) sel_q <= bus_wdata[3:0];
   end

   cm_timer8_wave #(.B_WINS(B_WINS)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_a_i  (evt_a),
      .evt_b_i  (evt_b),
      .code_a_i (sel_q[1:0]),
      .code_b_i (sel_q[3:2]),
      .level_o  (wave_out)
   );

   assign wave_oe = |sel_q;
   assign irq_a   = f_val[0];
   assign irq_b   = f_val[1];
   assign irq_ovf = f_val[2];

   always_comb begin
      case (bus_addr)
         ADR_COUNT: bus_rdata = DATA_W'(cnt);
         ADR_CMPA:  bus_rdata = DATA_W'(cmp_a);
         ADR_CMPB:  bus_rdata = DATA_W'(cmp_b);
         default:   bus_rdata = {f_val[1], f_val[0], f_val[2], 1'b1, sel_q};
      endcase
   end

   a_r8_rsv_high: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADR_CTRL) |-> bus_rdata[BIT_RSV]);
   a_r6_ack_spares_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ovf && !wr_ctrl) |=> irq_ovf);
endmodule

// File: tb/cm_timer8_tb_top.sv
module cm_timer8_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_en = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ack_a = 1'b0, ack_b = 1'b0;
   logic       wave_out, wave_oe, irq_a, irq_b, irq_ovf;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   cm_timer8 dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ack_a(ack_a), .ack_b(ack_b), .wave_out(wave_out), .wave_oe(wave_oe),
      .irq_a(irq_a), .irq_b(irq_b), .irq_ovf(irq_ovf)
   );

   // vector: {sel[3:0], cmp_a, cmp_b, steps, expected level}
   localparam logic [28:0] VEC [11] = '{
      {4'b0010, 8'h03, 8'hF0, 8'd5, 1'b1},
      {4'b0001, 8'h02, 8'hF0, 8'd4, 1'b0},
      {4'b0011, 8'h01, 8'hF0, 8'd2, 1'b1},
      {4'b0011, 8'h01, 8'hF0, 8'd2, 1'b0},
      {4'b1000, 8'hF0, 8'h03, 8'd3, 1'b1},
      {4'b0100, 8'hF0, 8'h03, 8'd3, 1'b0},
      {4'b1100, 8'hF0, 8'h02, 8'd4, 1'b1},
      {4'b0000, 8'h01, 8'h02, 8'd3, 1'b1},
      {4'b0110, 8'h02, 8'h02, 8'd3, 1'b0},
      {4'b1111, 8'h01, 8'h02, 8'd3, 1'b0},
      {4'b1110, 8'h03, 8'h03, 8'd3, 1'b1}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic step(input int n);
      @(negedge clk);
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic ack(input logic a, input logic b);
      @(negedge clk);
      ack_a = a; ack_b = b;
      @(negedge clk);
      ack_a = 1'b0; ack_b = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state, R8 reserved bit, R10 level and enable
      rd(2'd3, d); chk("R12 status", d, 8'h10);
      rd(2'd0, d); chk("R12 counter", d, 8'h00);
      rd(2'd1, d); chk("R12 cmp A", d, 8'hFF);
      rd(2'd2, d); chk("R12 cmp B", d, 8'hFF);
      chk("R10 reset level/oe", {6'd0, wave_out, wave_oe}, 8'h00);

      // R5 writing ones sets no flag, R8 reserved not writable
      wr(2'd3, 8'hEF); rd(2'd3, d); chk("R5 R8 status after ones", d, 8'h1F);
      wr(2'd3, 8'h00); rd(2'd3, d); chk("R8 status after zeros", d, 8'h10);

      // R9 R10 R11 action-code vectors
      for (int i = 0; i < 11; i++) begin
         wr(2'd0, 8'h00);
         wr(2'd1, VEC[i][24:17]);
         wr(2'd2, VEC[i][16:9]);
         wr(2'd3, {4'b0000, VEC[i][28:25]});
         step(int'(VEC[i][8:1]));
         chk("R9 R11 level", {7'd0, wave_out}, {7'd0, VEC[i][0]});
         chk("R10 oe", {7'd0, wave_oe}, {7'd0, |VEC[i][28:25]});
      end
      wr(2'd3, 8'h00);

      // R6 acknowledge clears compare flags
      ack(1'b1, 1'b1);
      chk("R6 ack clears A/B", {6'd0, irq_b, irq_a}, 8'h00);

      // R2 flag A, R1 increment
      wr(2'd2, 8'h80); wr(2'd1, 8'h05); wr(2'd0, 8'h04);
      step(1);
      chk("R2 flag A set", {7'd0, irq_a}, 8'h01);
      rd(2'd0, d); chk("R1 increment", d, 8'h05);

      // R4 write of 0 without an armed read leaves the flag
      wr(2'd3, 8'h00);
      chk("R4 unarmed write", {7'd0, irq_a}, 8'h01);
      rd(2'd3, d); chk("R8 status with A", d, 8'h50);
      wr(2'd3, 8'h00);
      chk("R4 armed clear", {7'd0, irq_a}, 8'h00);

      // R2 flag B, R5 writing 1 does not clear
      wr(2'd2, 8'h07); wr(2'd0, 8'h06);
      step(1);
      chk("R2 flag B set", {7'd0, irq_b}, 8'h01);
      rd(2'd3, d); wr(2'd3, 8'h80);
      chk("R5 write one keeps B", {7'd0, irq_b}, 8'h01);
      rd(2'd3, d); wr(2'd3, 8'h00);
      chk("R4 clear B", {7'd0, irq_b}, 8'h00);

      // R13 counter write suppresses match and overflow
      wr(2'd1, 8'h09); wr(2'd0, 8'h09);
      chk("R13 no match on load", {7'd0, irq_a}, 8'h00);
      wr(2'd0, 8'hFF); wr(2'd0, 8'h00);
      chk("R13 no ovf on load", {7'd0, irq_ovf}, 8'h00);
      wr(2'd0, 8'hFF);
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 8'h20; bus_wr = 1'b1; cnt_en = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; cnt_en = 1'b0;
      chk("R13 no ovf with enable", {7'd0, irq_ovf}, 8'h00);
      rd(2'd0, d); chk("R1 R13 load over increment", d, 8'h20);

      // R3 overflow, R1 wrap
      wr(2'd0, 8'hFE);
      step(2);
      chk("R3 overflow set", {7'd0, irq_ovf}, 8'h01);
      rd(2'd0, d); chk("R1 wrap", d, 8'h00);

      // R6 ack does not touch overflow
      wr(2'd1, 8'h11); wr(2'd0, 8'h10);
      step(1);
      chk("R2 flag A again", {7'd0, irq_a}, 8'h01);
      ack(1'b1, 1'b1);
      chk("R6 ack A and ovf", {6'd0, irq_ovf, irq_a}, 8'h02);

      // R7 set and clear in the same cycle
      wr(2'd1, 8'h30); wr(2'd0, 8'h2F);
      step(1);
      rd(2'd3, d);
      wr(2'd1, 8'h31);
      @(negedge clk);
      bus_addr = 2'd3; bus_wdata = 8'h20; bus_wr = 1'b1; cnt_en = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; cnt_en = 1'b0;
      chk("R7 set wins", {7'd0, irq_a}, 8'h01);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule